// File: doc/BRIEF.md
# Serial NAND Register and Status Engine

This block runs one register-level transaction at a time against a serial NAND flash. A host picks one of five commands, supplies a register address and a write value where needed, and pulses a start strobe. The engine then frames the transaction with an active-low chip select. It moves every byte through a byte-exchange handshake with an external bit shifter, and pulses a done strobe when the frame has closed. The result byte and the 16-bit identification word are then ready to read.

The five commands are: read a feature register, write a feature register, read the two-byte device identification, wait on the status register until it reads zero, and clear the two block-lock registers. The status wait keeps chip select low and clocks out dummy bytes until the device reports zero. A cycle counter bounds this wait. When the counter runs out, the command ends with the code 0xFF in place of a status value. The serial shifter, the serial clock and page transfers are outside this block.

Top module: `spinand_regctl`

## Requirements
- R1: After reset `cs_n` is 1, `xfer_req` and `cmd_done` are 0, and `cmd_result` and `cmd_id` are 0.
- R2: Host op 0 (feature read) sends the bytes 0x0F, `cmd_addr`, 0x00 in one chip-select frame. `cmd_result` becomes the byte received during the third exchange. Bytes received during the first two exchanges have no effect on the result.
- R3: Host op 1 (feature write) sends 0x1F, `cmd_addr`, `cmd_wdata` in one frame and returns `cmd_result` = 0x00.
- R4: Host op 2 (identification) sends 0x9F, 0x00, 0x00, 0x00 in one frame. `cmd_id` holds the fourth received byte in bits 15:8 and the third in bits 7:0. `cmd_result` = 0x00.
- R5: Host op 3 (status wait) sends 0x0F, 0xC0, then 0x00 dummy bytes in the same frame until a received status byte equals zero. `cmd_result` is then 0x00.
- R6: A down-counter is loaded with POLL_LIMIT when the 0xC0 exchange completes. If a nonzero status byte arrives after the counter has reached zero, the frame ends and `cmd_result` is 0xFF.
- R7: Host op 4 (unlock) sends two separate frames, 0x1F 0xB0 0x00 and then 0x1F 0xA0 0x00, in that order.
- R8: `xfer_req` is only high while `cs_n` is low, and it rises on the cycle after `cs_n` falls. `cs_n` is high for at least one cycle between frames and is high while `cmd_done` is high.
- R9: `xfer_req` stays high with `xfer_tx` unchanged until `xfer_ack`, and it is low on the cycle after `xfer_ack`.
- R10: `cmd_done` is a one-cycle pulse. `cmd_result` and `cmd_id` keep their values until the next accepted command.
- R11: A `cmd_start` while a command is in progress is ignored. A `cmd_start` with an op of 5 to 7 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start strobe, taken only when idle |
| cmd_op | input | 3 | Host op: 0 read feature, 1 write feature, 2 identification, 3 status wait, 4 unlock |
| cmd_addr | input | 8 | Feature register address |
| cmd_wdata | input | 8 | Feature register write value |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_result | output | 8 | Register value, status value or 0xFF timeout code |
| cmd_id | output | 16 | Identification word |
| cs_n | output | 1 | Active-low chip select |
| xfer_req | output | 1 | Byte exchange request to the shifter |
| xfer_tx | output | 8 | Byte to send |
| xfer_ack | input | 1 | Exchange finished, `xfer_rx` valid this cycle |
| xfer_rx | input | 8 | Byte received |

## Verification
A wrong byte index or frame counter shows up at the ports as soon as the next exchange: `xfer_tx` carries the wrong byte, or `cs_n` rises too early or too late. The bench records every exchanged byte and every frame, so this is caught when the command completes. A sequencer that loses its place in the handshake shows up within one cycle, because `xfer_req` stays high after an acknowledge or drops before one. A capture slot pointing at the wrong exchange shows up at `cmd_done` as a result or ID holding the filler bytes the device model returns during the opcode and address exchanges. The timeout path is exercised against a device that never becomes ready, so a counter that never expires hangs the run and is caught by the watchdog.

// File: rtl/spinand_regctl_pkg.sv
package spinand_regctl_pkg;
  localparam int BYTE_W = 8;
  localparam int ID_W   = 2 * BYTE_W;

  typedef enum logic [2:0] {
    OP_GET_FEAT = 3'd0,
    OP_SET_FEAT = 3'd1,
    OP_READ_ID  = 3'd2,
    OP_POLL     = 3'd3,
    OP_UNLOCK   = 3'd4
  } host_op_e;

  localparam logic [BYTE_W-1:0] NAND_GET_FEAT = 8'h0F;
  localparam logic [BYTE_W-1:0] NAND_SET_FEAT = 8'h1F;
  localparam logic [BYTE_W-1:0] NAND_READ_ID  = 8'h9F;
  localparam logic [BYTE_W-1:0] REG_STATUS    = 8'hC0;
  localparam logic [BYTE_W-1:0] REG_LOCK_1ST  = 8'hB0;
  localparam logic [BYTE_W-1:0] REG_LOCK_2ND  = 8'hA0;
  localparam logic [BYTE_W-1:0] FILL_BYTE     = 8'h00;
  localparam logic [BYTE_W-1:0] TIMEOUT_CODE  = 8'hFF;

  function automatic logic op_known(logic [2:0] op);
    return op <= 3'd4;
  endfunction

  // Byte sent at position idx of frame frm for a given host op.
  function automatic logic [BYTE_W-1:0] script_byte(host_op_e op, logic frm,
                                                    logic [1:0] idx,
                                                    logic [BYTE_W-1:0] addr,
                                                    logic [BYTE_W-1:0] wdata);
    logic [BYTE_W-1:0] b;
    b = FILL_BYTE;
    case (op)
      OP_GET_FEAT: b = (idx == 2'd0) ? NAND_GET_FEAT : (idx == 2'd1) ? addr : FILL_BYTE;
      OP_SET_FEAT: b = (idx == 2'd0) ? NAND_SET_FEAT : (idx == 2'd1) ? addr : wdata;
      OP_READ_ID:  b = (idx == 2'd0) ? NAND_READ_ID : FILL_BYTE;
      OP_POLL:     b = (idx == 2'd0) ? NAND_GET_FEAT : (idx == 2'd1) ? REG_STATUS : FILL_BYTE;
      OP_UNLOCK:   b = (idx == 2'd0) ? NAND_SET_FEAT :
                       (idx == 2'd1) ? (frm ? REG_LOCK_2ND : REG_LOCK_1ST) : FILL_BYTE;
      default:     b = FILL_BYTE;
    endcase
    return b;
  endfunction

  // Index of the last byte of a frame (status wait: last fixed byte).
  function automatic logic [1:0] script_last_idx(host_op_e op);
    return (op == OP_READ_ID) ? 2'd3 : 2'd2;
  endfunction

  function automatic logic script_last_frame(host_op_e op, logic frm);
    return (op == OP_UNLOCK) ? frm : 1'b1;
  endfunction
endpackage

// File: rtl/spinand_script.sv
module spinand_script
  import spinand_regctl_pkg::*;
(
  input  host_op_e          op,
  input  logic              frm,
  input  logic [1:0]        idx,
  input  logic [BYTE_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              last_idx,
  output logic              last_frame,
  output logic              status_phase
);
  always_comb begin
    tx_byte      = script_byte(op, frm, idx, addr, wdata);
    last_idx     = (idx == script_last_idx(op));
    last_frame   = script_last_frame(op, frm);
    status_phase = (op == OP_POLL) && (idx >= 2'd2);
  end
endmodule

// File: rtl/spinand_poll_timer.sv
module spinand_poll_timer #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(LIMIT);

  logic [CW-1:0] remaining;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remaining <= '0;
    else if (load)             remaining <= LOAD_VAL;
    else if (remaining != '0)  remaining <= remaining - 1'b1;
  end

  assign expired = (remaining == '0);
endmodule

// File: rtl/spinand_capture.sv
module spinand_capture
  import spinand_regctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rx_evt,
  input  logic              timeout_evt,
  input  host_op_e          op,
  input  logic [1:0]        idx,
  input  logic [BYTE_W-1:0] rx,
  output logic [BYTE_W-1:0] result,
  output logic [ID_W-1:0]   id
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      id     <= '0;
    end else if (clear) begin
      result <= '0;
    end else if (timeout_evt) begin
      result <= TIMEOUT_CODE;
    end else if (rx_evt) begin
      case (op)
        OP_GET_FEAT: if (idx == 2'd2) result <= rx;
        OP_POLL:     if (idx >= 2'd2) result <= rx;
        OP_READ_ID: begin
          if (idx == 2'd2) id[BYTE_W-1:0]    <= rx;
          if (idx == 2'd3) id[ID_W-1:BYTE_W] <= rx;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spinand_regctl.sv
module spinand_regctl
  import spinand_regctl_pkg::*;
#(
  parameter int POLL_LIMIT = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [2:0]        cmd_op,
  input  logic [BYTE_W-1:0] cmd_addr,
  input  logic [BYTE_W-1:0] cmd_wdata,
  output logic              cmd_done,
  output logic [BYTE_W-1:0] cmd_result,
  output logic [ID_W-1:0]   cmd_id,
  output logic              cs_n,
  output logic              xfer_req,
  output logic [BYTE_W-1:0] xfer_tx,
  input  logic              xfer_ack,
  input  logic [BYTE_W-1:0] xfer_rx
);
  typedef enum logic [2:0] {S_IDLE, S_SEL, S_XFER, S_NEXT, S_DESEL, S_DONE} eng_state_e;

  eng_state_e        state;
  host_op_e          op_q;
  logic [BYTE_W-1:0] addr_q, wdata_q, rx_q;
  logic              frame_q;
  logic [1:0]        idx_q;

  // Named internal events
  logic accept, rx_evt, timer_load, timer_expired;
  logic last_idx, last_frame, status_phase;
  logic ready_evt, timeout_evt, frame_end, eng_busy;

  spinand_script u_script (
    .op(op_q), .frm(frame_q), .idx(idx_q), .addr(addr_q), .wdata(wdata_q),
    .tx_byte(xfer_tx), .last_idx(last_idx), .last_frame(last_frame),
    .status_phase(status_phase)
  );

  spinand_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .expired(timer_expired)
  );

  spinand_capture u_capture (
    .clk(clk), .rst_n(rst_n), .clear(accept), .rx_evt(rx_evt),
    .timeout_evt(timeout_evt), .op(op_q), .idx(idx_q), .rx(xfer_rx),
    .result(cmd_result), .id(cmd_id)
  );

  assign eng_busy    = (state != S_IDLE);
  assign accept      = (state == S_IDLE) && cmd_start && op_known(cmd_op);
  assign rx_evt      = (state == S_XFER) && xfer_ack;
  assign timer_load  = rx_evt && (op_q == OP_POLL) && (idx_q == 2'd1);
  assign ready_evt   = (state == S_NEXT) && status_phase && (rx_q == '0);
  assign timeout_evt = (state == S_NEXT) && status_phase && (rx_q != '0) && timer_expired;
  assign frame_end   = status_phase ? ((rx_q == '0) || timer_expired) : last_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= OP_GET_FEAT;
      addr_q  <= '0;
      wdata_q <= '0;
      rx_q    <= '0;
      frame_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          op_q    <= host_op_e'(cmd_op);
          addr_q  <= cmd_addr;
          wdata_q <= cmd_wdata;
          frame_q <= 1'b0;
          idx_q   <= '0;
          state   <= S_SEL;
        end
        S_SEL: state <= S_XFER;
        S_XFER: if (xfer_ack) begin
          rx_q  <= xfer_rx;
          state <= S_NEXT;
        end
        S_NEXT: begin
          if (frame_end) state <= S_DESEL;
          else begin
            if (!status_phase) idx_q <= idx_q + 1'b1;
            state <= S_XFER;
          end
        end
        S_DESEL: begin
          if (last_frame) state <= S_DONE;
          else begin
            frame_q <= 1'b1;
            idx_q   <= '0;
            state   <= S_SEL;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cs_n     = !((state == S_SEL) || (state == S_XFER) || (state == S_NEXT));
  assign xfer_req = (state == S_XFER);
  assign cmd_done = (state == S_DONE);
endmodule

module spinand_regctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       xfer_req,
  input logic       xfer_ack,
  input logic [7:0] xfer_tx,
  input logic       cmd_done,
  input logic [7:0] cmd_result,
  input logic       cmd_start,
  input logic       eng_busy,
  input logic [2:0] eng_op,
  input logic       timeout_evt
);
  assert_req_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> !cs_n);
  assert_sel_to_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |=> xfer_req);
  assert_done_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> cs_n);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx)));
  assert_req_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_ack) |=> !xfer_req);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);
  assert_timeout_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (cmd_result == 8'hFF));
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && cmd_start) |=> $stable(eng_op));
endmodule

bind spinand_regctl spinand_regctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .xfer_req(xfer_req),
  .xfer_ack(xfer_ack), .xfer_tx(xfer_tx), .cmd_done(cmd_done),
  .cmd_result(cmd_result), .cmd_start(cmd_start), .eng_busy(eng_busy),
  .eng_op(op_q), .timeout_evt(timeout_evt)
);

// File: tb/sim_spinand_regctl.sv
`timescale 1ns/1ps
module sim_spinand_regctl;
  localparam int LIMIT = 60;
  localparam int LAT   = 2;
  localparam logic [7:0] ID_LO = 8'h2C, ID_HI = 8'h24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_addr = '0, cmd_wdata = '0;
  logic cmd_done, cs_n, xfer_req;
  logic [7:0] cmd_result, xfer_tx;
  logic [15:0] cmd_id;
  logic xfer_ack = 1'b0;
  logic [7:0] xfer_rx = '0;

  always #5 clk = ~clk;

  spinand_regctl #(.POLL_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_done(cmd_done),
    .cmd_result(cmd_result), .cmd_id(cmd_id), .cs_n(cs_n),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx)
  );

  int checks = 0, failures = 0;

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- device + shifter model ----------------
  logic [7:0] feat [256];
  logic [7:0] tx_log [$];
  int frames = 0, busy_rem = 0, dev_idx = 0, wait_cnt = 0, low_cyc = 0;
  int sel_lat = -1;
  logic [7:0] dev_op = '0, dev_addr = '0;
  logic cs_prev = 1'b1;

  always @(posedge clk) begin
    logic [7:0] r;
    xfer_ack <= 1'b0;
    if (cs_prev && !cs_n) frames++;
    cs_prev = cs_n;
    if (cs_n) begin
      dev_idx = 0; wait_cnt = 0; low_cyc = 0;
    end else begin
      if (xfer_req && dev_idx == 0 && wait_cnt == 0) sel_lat = low_cyc;
      low_cyc++;
      if (xfer_req && !xfer_ack) begin
        if (wait_cnt == LAT) begin
          wait_cnt = 0;
          tx_log.push_back(xfer_tx);
          r = 8'hA5;
          if (dev_idx == 0) dev_op = xfer_tx;
          else if (dev_idx == 1) begin dev_addr = xfer_tx; r = 8'h5A; end
          else case (dev_op)
            8'h0F: if (dev_addr == 8'hC0) begin
                     r = (busy_rem > 0) ? 8'h01 : 8'h00;
                     if (busy_rem > 0) busy_rem--;
                   end else r = feat[dev_addr];
            8'h1F: begin if (dev_idx == 2) feat[dev_addr] = xfer_tx; r = 8'h77; end
            8'h9F: r = (dev_idx == 2) ? ID_LO : (dev_idx == 3) ? ID_HI : 8'h00;
            default: r = 8'h00;
          endcase
          dev_idx++;
          xfer_ack <= 1'b1;
          xfer_rx  <= r;
        end else wait_cnt++;
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    string       tag;
    logic [7:0]  res;
    logic [15:0] id;
    bit          chk_id;
    int          nb;      // -1: skip byte compare
    logic [63:0] bytes;   // byte i at [8*i +: 8]
    int          nfr;
  } exp_t;
  exp_t exp_q[$];
  int done_seen = 0;

  always @(negedge clk) begin
    if (rst_n && cmd_done) begin
      if (exp_q.size() == 0) check(1'b0, "R11 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check(cmd_result == e.res, {e.tag, " result"}, cmd_result, e.res);
        if (e.chk_id) check(cmd_id == e.id, {e.tag, " id"}, cmd_id, e.id);
        check(frames == e.nfr, {e.tag, " frames"}, frames, e.nfr);
        if (e.nb >= 0) begin
          bit ok;
          ok = (tx_log.size() == e.nb);
          for (int i = 0; i < e.nb && i < tx_log.size(); i++)
            if (tx_log[i] != e.bytes[8*i +: 8]) ok = 1'b0;
          check(ok, {e.tag, " tx bytes"}, tx_log.size(), e.nb);
        end
      end
      done_seen++;
    end
  end

  task automatic issue(logic [2:0] op, logic [7:0] a, logic [7:0] w, exp_t e);
    int target;
    tx_log.delete();
    frames = 0;
    exp_q.push_back(e);
    target = done_seen + 1;
    @(negedge clk); cmd_op = op; cmd_addr = a; cmd_wdata = w; cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
    while (done_seen < target) @(negedge clk);
  endtask

  function automatic exp_t mk(string t, logic [7:0] r, int nb, logic [63:0] b, int nfr);
    exp_t e;
    e.tag = t; e.res = r; e.id = '0; e.chk_id = 1'b0; e.nb = nb; e.bytes = b; e.nfr = nfr;
    return e;
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    exp_t e;
    logic [7:0] held;
    for (int i = 0; i < 256; i++) feat[i] = 8'(i ^ 8'h3C);
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
    check(xfer_req == 1'b0 && cmd_done == 1'b0, "R1 req/done", {xfer_req, cmd_done}, 0);
    check(cmd_result == 8'h00 && cmd_id == 16'h0, "R1 result/id", {cmd_result, cmd_id}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 feature read
    issue(3'd0, 8'h10, 8'h00, mk("R2 read 0x10", 8'h2C, 3, {40'h0, 8'h00, 8'h10, 8'h0F}, 1));
    check(sel_lat == 1, "R8 req one cycle after cs fall", sel_lat, 1);
    feat[8'h55] = 8'h00;
    issue(3'd0, 8'h55, 8'h00, mk("R2 read zero reg", 8'h00, 3, {40'h0, 8'h00, 8'h55, 8'h0F}, 1));

    // R3 feature write then read back
    issue(3'd1, 8'h20, 8'h9E, mk("R3 write", 8'h00, 3, {40'h0, 8'h9E, 8'h20, 8'h1F}, 1));
    check(feat[8'h20] == 8'h9E, "R3 device reg", feat[8'h20], 8'h9E);
    issue(3'd0, 8'h20, 8'h00, mk("R2 readback", 8'h9E, 3, {40'h0, 8'h00, 8'h20, 8'h0F}, 1));

    // R4 identification
    e = mk("R4 id", 8'h00, 4, {32'h0, 8'h00, 8'h00, 8'h00, 8'h9F}, 1);
    e.chk_id = 1'b1; e.id = {ID_HI, ID_LO};
    issue(3'd2, 8'h00, 8'h00, e);

    // R10 outputs hold after done
    held = cmd_result;
    repeat (10) @(negedge clk);
    check(cmd_id == {ID_HI, ID_LO} && cmd_result == held, "R10 hold", cmd_id, {ID_HI, ID_LO});

    // R5 status wait, immediately ready and ready after 3 busy bytes
    busy_rem = 0;
    issue(3'd3, 8'h00, 8'h00, mk("R5 poll ready", 8'h00, 3, {40'h0, 8'h00, 8'hC0, 8'h0F}, 1));
    busy_rem = 3;
    issue(3'd3, 8'h00, 8'h00,
          mk("R5 poll busy3", 8'h00, 6, {16'h0, 8'h00, 8'h00, 8'h00, 8'h00, 8'hC0, 8'h0F}, 1));

    // R6 timeout
    busy_rem = 100000;
    issue(3'd3, 8'h00, 8'h00, mk("R6 poll timeout", 8'hFF, -1, 64'h0, 1));
    check(tx_log.size() > 3 && tx_log[1] == 8'hC0, "R6 polled repeatedly", tx_log.size(), 4);
    busy_rem = 0;

    // R7 unlock
    feat[8'hB0] = 8'h5A; feat[8'hA0] = 8'h38;
    issue(3'd4, 8'h00, 8'h00,
          mk("R7 unlock", 8'h00, 6, {16'h0, 8'h00, 8'hA0, 8'h1F, 8'h00, 8'hB0, 8'h1F}, 2));
    check(feat[8'hB0] == 8'h00 && feat[8'hA0] == 8'h00, "R7 regs cleared",
          {feat[8'hB0], feat[8'hA0]}, 0);

    // R11 start while busy is ignored
    feat[8'h30] = 8'h3C;
    tx_log.delete(); frames = 0;
    exp_q.push_back(mk("R11 busy read", 8'h3C, 3, {40'h0, 8'h00, 8'h30, 8'h0F}, 1));
    begin
      int target;
      target = done_seen + 1;
      @(negedge clk); cmd_op = 3'd0; cmd_addr = 8'h30; cmd_start = 1'b1;
      @(negedge clk); cmd_start = 1'b0;
      repeat (4) @(negedge clk);
      cmd_op = 3'd1; cmd_addr = 8'h30; cmd_wdata = 8'hEE; cmd_start = 1'b1;
      @(negedge clk); cmd_start = 1'b0;
      while (done_seen < target) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    check(frames == 1 && tx_log.size() == 3, "R11 no second command", tx_log.size(), 3);
    check(feat[8'h30] == 8'h3C, "R11 reg untouched", feat[8'h30], 8'h3C);

    // R11 unknown op starts nothing
    tx_log.delete(); frames = 0;
    @(negedge clk); cmd_op = 3'd6; cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
    repeat (15) @(negedge clk);
    check(frames == 0 && cs_n == 1'b1, "R11 unknown op", frames, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule